// File: doc/BRIEF.md
# Packetized OTP Read Controller

This block reads a one-time-programmable word array whose contents form a chain of variable-length packets. Every packet opens with a 32-bit header whose size field gives the payload length; the payload follows as size+1 words, so the next packet begins size+2 words after the current header. Software places a word address in a mode register and sets a start bit in a control register. The controller then walks the header chain from word 0 until it reaches the packet whose range holds that address. It copies the header and the payload into local buffers and shows a busy flag while it works.

After the load, software reads the header through its own register. It streams the payload through a data register that advances by one word on every read. An index register rewinds or repositions that stream. A zero-size header ends the chain. If the walk runs off the end of the array, the load returns all-zero buffers. The array sits outside the block as a synchronous ROM with one cycle of read latency, and it holds 11 KiB (2816 words) by default.

Top module: `otp_pkt_reader`

## Requirements
- R1: After reset the status busy bit (bit 6 of 0x0C), the header register (0x20), the data register (0x24) and the mode register (0x04) all read 0.
- R2: The mode register at 0x04 holds the target word address in bits 31:16, and reading it back returns that field with bits 15:0 as zero. A read of the control register at 0x00 returns 0.
- R3: A write to 0x00 with bit 6 set starts a load. Status bit 6 reads 1 from the cycle after the write is accepted until the load completes, and then reads 0. A write to 0x00 with bit 6 clear starts nothing.
- R4: A target address anywhere in [start of packet k, start of packet k + size_k + 2) loads packet k. The header register then returns packet k's header word, where size_k is header bits 15:8.
- R5: After a load, successive reads of 0x24 return the size_k+1 payload words in address order, starting at word 0 of the payload. Payload words at or beyond the end of the array read as 0.
- R6: A read of 0x24 once all payload words are consumed returns 0 and does not move the index, so further reads also return 0.
- R7: A write to 0x08 sets the payload index to the written value, saturated at 256. Writing 0 rewinds the stream to the first payload word.
- R8: A walk that meets a header with size 0, or whose header position reaches the end of the array before the target is enclosed, leaves the header register at 0 and makes every data read return 0.
- R9: A start write while the busy flag is set is ignored. The load already in progress completes for the target captured at its own start, even if the mode register has been rewritten.
- R10: Every request is accepted in the cycle it is presented. Read data is returned with rsp_valid exactly one cycle after a read request, and rsp_valid is low in every cycle after a cycle with no read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data |
| otp_en | output | 1 | ROM read enable |
| otp_addr | output | AW | ROM word address |
| otp_rdata | input | 32 | ROM data, valid one cycle after otp_en |

## Verification
The walk is tried with three kinds of target.

- **Targets on a header word:** these separate an exact hit from an off-by-one in the next-packet arithmetic.
- **Targets on the last payload word of a packet:** these show whether the range ends at size+2 or one word early.
- **Random targets over a chain of random short packets:** these test the chained walk at many depths.

A second array layout has a maximum-size packet that runs past the end of the array. It shows apart three cases: zero-filling of missing payload, loading a packet whose range extends past the array end, and failing once the next header position lies past the end. Overlapping start requests, index repositioning and reads past the stream end show whether the target is latched and whether the index saturates.

// File: rtl/otp_pkt_pkg.sv
package otp_pkt_pkg;
  localparam logic [7:0] REG_CTRL = 8'h00;
  localparam logic [7:0] REG_MODE = 8'h04;
  localparam logic [7:0] REG_AUX  = 8'h08;
  localparam logic [7:0] REG_STAT = 8'h0C;
  localparam logic [7:0] REG_HDR  = 8'h20;
  localparam logic [7:0] REG_DATA = 8'h24;
  localparam int START_BIT = 6;
  localparam int BUSY_BIT  = 6;
  localparam int SIZE_W    = 8;
  localparam int MAX_PLD   = (1 << SIZE_W);
  localparam int CNT_W     = $clog2(MAX_PLD + 1);
  localparam int IDX_W     = $clog2(MAX_PLD);
  localparam int POS_W     = 17;

  typedef enum logic [2:0] {W_IDLE, W_HREQ, W_HCHK, W_PREQ, W_PCAP} walk_state_e;

  function automatic logic [SIZE_W-1:0] hdr_size(input logic [31:0] h);
    return h[15:8];
  endfunction

  function automatic logic [POS_W-1:0] next_start(input logic [POS_W-1:0] p,
                                                  input logic [SIZE_W-1:0] s);
    return p + POS_W'(s) + POS_W'(2);
  endfunction

  function automatic logic [CNT_W-1:0] pld_words(input logic [SIZE_W-1:0] s);
    return CNT_W'(s) + CNT_W'(1);
  endfunction
endpackage

// File: rtl/otp_pkt_walker.sv
module otp_pkt_walker
  import otp_pkt_pkg::*;
#(
  parameter int OTP_WORDS = 2816,
  parameter int AW = $clog2(OTP_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic [15:0]       target,
  output logic              otp_en,
  output logic [AW-1:0]     otp_addr,
  input  logic [31:0]       otp_rdata,
  output logic              busy,
  output logic              hdr_we,
  output logic [31:0]       hdr_word,
  output logic [CNT_W-1:0]  hdr_count,
  output logic              pld_we,
  output logic [IDX_W-1:0]  pld_idx,
  output logic [31:0]       pld_word,
  output logic              load_fail
);
  localparam logic [POS_W-1:0] LIMIT = POS_W'(OTP_WORDS);

  walk_state_e      state_q;
  logic [POS_W-1:0] pos_q;
  logic [15:0]      target_q;
  logic [CNT_W-1:0] cnt_q, widx_q;

  logic [SIZE_W-1:0] sz;
  logic [POS_W-1:0]  nxt, paddr;
  logic              pend_oob, last_w, pos_oob;

  always_comb begin
    sz       = hdr_size(otp_rdata);
    nxt      = next_start(pos_q, sz);
    paddr    = pos_q + POS_W'(1) + POS_W'(widx_q);
    pend_oob = paddr >= LIMIT;
    pos_oob  = pos_q >= LIMIT;
    last_w   = (widx_q + CNT_W'(1)) == cnt_q;
    busy     = state_q != W_IDLE;
    otp_en   = (state_q == W_HREQ && !pos_oob) || (state_q == W_PREQ && !pend_oob);
    otp_addr = (state_q == W_PREQ) ? paddr[AW-1:0] : pos_q[AW-1:0];
    hdr_we   = state_q == W_HCHK && sz != '0 && {1'b0, target_q} < nxt;
    hdr_word = otp_rdata;
    hdr_count = pld_words(sz);
    load_fail = (state_q == W_HREQ && pos_oob) || (state_q == W_HCHK && sz == '0);
    pld_we   = (state_q == W_PCAP) || (state_q == W_PREQ && pend_oob);
    pld_word = (state_q == W_PCAP) ? otp_rdata : 32'h0;
    pld_idx  = widx_q[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= W_IDLE;
      pos_q    <= '0;
      target_q <= '0;
      cnt_q    <= '0;
      widx_q   <= '0;
    end else begin
      case (state_q)
        W_IDLE: if (start_req) begin
          target_q <= target;
          pos_q    <= '0;
          state_q  <= W_HREQ;
        end
        W_HREQ: state_q <= load_fail ? W_IDLE : W_HCHK;
        W_HCHK: begin
          if (sz == '0) state_q <= W_IDLE;
          else if (hdr_we) begin
            cnt_q   <= pld_words(sz);
            widx_q  <= '0;
            state_q <= W_PREQ;
          end else begin
            pos_q   <= nxt;
            state_q <= W_HREQ;
          end
        end
        W_PREQ: begin
          if (!pend_oob) state_q <= W_PCAP;
          else if (last_w) state_q <= W_IDLE;
          else widx_q <= widx_q + CNT_W'(1);
        end
        W_PCAP: begin
          if (last_w) state_q <= W_IDLE;
          else begin
            widx_q  <= widx_q + CNT_W'(1);
            state_q <= W_PREQ;
          end
        end
        default: state_q <= W_IDLE;
      endcase
    end
  end

  p_busy_after_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_req) |=> busy);
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_req) |=> $stable(target_q));
  p_rom_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    otp_en |-> (32'(otp_addr) < OTP_WORDS));
  p_idle_after_fail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_fail |=> !busy);
endmodule

// File: rtl/otp_pkt_buf.sv
module otp_pkt_buf
  import otp_pkt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              hdr_we,
  input  logic [31:0]       hdr_word,
  input  logic [CNT_W-1:0]  hdr_count,
  input  logic              pld_we,
  input  logic [IDX_W-1:0]  pld_idx,
  input  logic [31:0]       pld_word,
  input  logic              aux_we,
  input  logic [CNT_W-1:0]  aux_val,
  input  logic              rd_pop,
  output logic [31:0]       header,
  output logic [31:0]       cur_word
);
  logic [31:0]      mem_q [MAX_PLD];
  logic [CNT_W-1:0] cnt_q, idx_q;
  logic             have;

  always_comb begin
    have     = idx_q < cnt_q;
    cur_word = have ? mem_q[idx_q[IDX_W-1:0]] : 32'h0;
  end

  always_ff @(posedge clk) begin
    if (pld_we) mem_q[pld_idx] <= pld_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      header <= '0;
      cnt_q  <= '0;
      idx_q  <= '0;
    end else if (clr) begin
      header <= '0;
      cnt_q  <= '0;
      idx_q  <= '0;
    end else if (hdr_we) begin
      header <= hdr_word;
      cnt_q  <= hdr_count;
      idx_q  <= '0;
    end else if (aux_we) begin
      idx_q <= aux_val;
    end else if (rd_pop && have) begin
      idx_q <= idx_q + CNT_W'(1);
    end
  end

  p_no_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && !have && !aux_we && !hdr_we && !clr) |=> $stable(idx_q));
  p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (header == 32'h0 && cur_word == 32'h0));
endmodule

// File: rtl/otp_pkt_reader.sv
module otp_pkt_reader
  import otp_pkt_pkg::*;
#(
  parameter int OTP_WORDS = 2816,
  parameter int AW = $clog2(OTP_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [7:0]    req_addr,
  input  logic [31:0]   req_wdata,
  output logic          rsp_valid,
  output logic [31:0]   rsp_rdata,
  output logic          otp_en,
  output logic [AW-1:0] otp_addr,
  input  logic [31:0]   otp_rdata
);
  logic wr_evt, rd_evt, start_evt, aux_evt, pop_evt;
  logic [15:0] mode_q;
  logic busy, hdr_we, pld_we, load_fail;
  logic [31:0] hdr_word, pld_word, header, cur_word, rd_mux;
  logic [CNT_W-1:0] hdr_count, aux_val;
  logic [IDX_W-1:0] pld_idx;

  always_comb begin
    req_ready = 1'b1;
    wr_evt    = req_valid && req_write;
    rd_evt    = req_valid && !req_write;
    start_evt = wr_evt && req_addr == REG_CTRL && req_wdata[START_BIT];
    aux_evt   = wr_evt && req_addr == REG_AUX;
    pop_evt   = rd_evt && req_addr == REG_DATA;
    aux_val   = (req_wdata > 32'(MAX_PLD)) ? CNT_W'(MAX_PLD) : req_wdata[CNT_W-1:0];
    case (req_addr)
      REG_MODE: rd_mux = {mode_q, 16'h0};
      REG_STAT: rd_mux = 32'(busy) << BUSY_BIT;
      REG_HDR:  rd_mux = header;
      REG_DATA: rd_mux = cur_word;
      default:  rd_mux = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (wr_evt && req_addr == REG_MODE) mode_q <= req_wdata[31:16];
      rsp_valid <= rd_evt;
      if (rd_evt) rsp_rdata <= rd_mux;
    end
  end

  otp_pkt_walker #(.OTP_WORDS(OTP_WORDS), .AW(AW)) walk_i (
    .clk(clk), .rst_n(rst_n), .start_req(start_evt), .target(mode_q),
    .otp_en(otp_en), .otp_addr(otp_addr), .otp_rdata(otp_rdata),
    .busy(busy), .hdr_we(hdr_we), .hdr_word(hdr_word), .hdr_count(hdr_count),
    .pld_we(pld_we), .pld_idx(pld_idx), .pld_word(pld_word), .load_fail(load_fail)
  );

  otp_pkt_buf buf_i (
    .clk(clk), .rst_n(rst_n), .clr(load_fail), .hdr_we(hdr_we),
    .hdr_word(hdr_word), .hdr_count(hdr_count), .pld_we(pld_we),
    .pld_idx(pld_idx), .pld_word(pld_word), .aux_we(aux_evt),
    .aux_val(aux_val), .rd_pop(pop_evt), .header(header), .cur_word(cur_word)
  );

  p_rsp_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_evt |=> rsp_valid);
  p_no_stray_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_evt |=> !rsp_valid);
endmodule

// File: tb/otp_pkt_reader_tb.sv
module otp_pkt_reader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 256;
  localparam int AW = $clog2(W);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_ready, rsp_valid, otp_en;
  logic [7:0] req_addr = '0;
  logic [31:0] req_wdata = '0, rsp_rdata, otp_rdata;
  logic [AW-1:0] otp_addr;
  logic [31:0] mem [W];
  int starts [64];
  int sizes [64];
  int npk = 0;
  int n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) if (otp_en) otp_rdata <= mem[otp_addr];

  otp_pkt_reader #(.OTP_WORDS(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .otp_en(otp_en),
    .otp_addr(otp_addr), .otp_rdata(otp_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 rsp_valid", 32'(rsp_valid), 32'h1);
    d = rsp_rdata;
  endtask

  function automatic int find_pkt(input int t);
    for (int k = 0; k < npk; k++)
      if (t < starts[k] + sizes[k] + 2) return k;
    return -1;
  endfunction

  function automatic logic [31:0] exp_word(input int k, input int j);
    int a = starts[k] + 1 + j;
    return (a < W) ? mem[a] : 32'h0;
  endfunction

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(8'h0C, s);
      if (s[6] == 1'b0) return;
    end
    check("R3 busy never clears", 32'h1, 32'h0);
  endtask

  task automatic start_load(input int t);
    logic [31:0] s;
    wr(8'h04, {16'(t), 16'h0});
    wr(8'h00, 32'h40);
    rd(8'h0C, s);
    check("R3 busy after start", 32'(s[6]), 32'h1);
    wait_idle();
  endtask

  task automatic check_pkt(input int t);
    logic [31:0] v;
    int k = find_pkt(t);
    start_load(t);
    rd(8'h20, v);
    if (k < 0) begin
      check("R8 header zero", v, 32'h0);
      rd(8'h24, v); check("R8 data zero", v, 32'h0);
      rd(8'h24, v); check("R8 data zero", v, 32'h0);
    end else begin
      check("R4 header", v, mem[starts[k]]);
      for (int j = 0; j <= sizes[k]; j++) begin
        rd(8'h24, v); check("R5 payload", v, exp_word(k, j));
      end
      rd(8'h24, v); check("R6 past end", v, 32'h0);
      rd(8'h24, v); check("R6 no advance", v, 32'h0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int pos, sz, seed, term;
    seed = $urandom(32'd1234);
    for (int i = 0; i < W; i++) mem[i] = $urandom;
    pos = 0;
    while (npk < 40) begin
      sz = $urandom_range(1, 7);
      if (pos + sz + 2 > 220) break;
      mem[pos] = {16'($urandom), 8'(sz), 8'($urandom)};
      starts[npk] = pos; sizes[npk] = sz; npk++;
      pos += sz + 2;
    end
    term = pos;
    mem[term] = {16'($urandom), 8'h00, 8'($urandom)};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(8'h0C, v); check("R1 status reset", v, 32'h0);
    rd(8'h20, v); check("R1 header reset", v, 32'h0);
    rd(8'h24, v); check("R1 data reset", v, 32'h0);
    rd(8'h04, v); check("R1 mode reset", v, 32'h0);

    wr(8'h04, 32'hABCD_1234);
    rd(8'h04, v); check("R2 mode field", v, 32'hABCD_0000);
    rd(8'h00, v); check("R2 ctrl reads 0", v, 32'h0);
    wr(8'h00, 32'hFFFF_FFBF);
    rd(8'h0C, v); check("R3 no start without bit6", v, 32'h0);

    check_pkt(0);
    check_pkt(starts[1] + sizes[1] + 1);
    check_pkt(starts[2] + 1);
    check_pkt(term);
    check_pkt(term + 5);
    check_pkt(W - 1);
    for (int i = 0; i < 20; i++) check_pkt($urandom_range(0, W - 1));

    check_pkt(starts[4]);
    wr(8'h08, 32'h0);
    rd(8'h24, v); check("R7 rewind", v, exp_word(4, 0));
    wr(8'h08, 32'h1);
    rd(8'h24, v); check("R7 index 1", v, exp_word(4, 1));
    wr(8'h08, 32'd1000);
    rd(8'h24, v); check("R7 saturate", v, 32'h0);

    wr(8'h04, {16'(starts[5]), 16'h0});
    wr(8'h00, 32'h40);
    wr(8'h04, 32'h0);
    wr(8'h00, 32'h40);
    wait_idle();
    rd(8'h20, v); check("R9 busy start ignored", v, mem[starts[5]]);
    rd(8'h24, v); check("R9 payload of first", v, exp_word(5, 0));

    for (int i = 0; i < W; i++) mem[i] = $urandom;
    npk = 0;
    mem[0] = {16'($urandom), 8'd3, 8'($urandom)};
    starts[0] = 0; sizes[0] = 3;
    mem[5] = {16'($urandom), 8'd255, 8'($urandom)};
    starts[1] = 5; sizes[1] = 255;
    npk = 2;
    check_pkt(2);
    check_pkt(7);
    check_pkt(261);
    check_pkt(262);
    check_pkt(16'hFFFF);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule